// File: doc/BRIEF.md
# Single to Half Precision Float Narrower

This block converts a 32-bit IEEE 754 single-precision bit pattern into the nearest 16-bit IEEE 754 half-precision bit pattern. It is meant to sit in a datapath that stores or forwards values in the narrower format. A word that arrives with its valid strobe high is converted, and the result appears on a registered output one clock later with its own valid strobe.

Rounding is to nearest, and exact ties go to the even candidate. The rounding point follows the input exponent. Below the smallest normal half exponent it stays fixed at the half subnormal step of 2^-24. Small magnitudes therefore become half subnormals or signed zero, and magnitudes above the half range saturate to infinity. Every NaN becomes a single canonical quiet NaN. The input sign is always copied through.

Top module: `sp_to_hp_narrow`

## Requirements
- R1: An input with exponent field 0xFF and a nonzero mantissa field produces output bits [14:0] = 0x7E00.
- R2: An input with exponent field 143 or more that is not a NaN, which includes single infinity, produces output bits [14:0] = 0x7C00.
- R3: Output bit 15 equals input bit 31 for every converted word, including zero, NaN and infinity results.
- R4: For input exponent fields 113 to 142, the output exponent field is the input exponent minus 112. The output mantissa is input mantissa bits [22:13], rounded to nearest using bit 12 and the bits below it, with exact ties going to an even output bit 0.
- R5: For input exponent fields 1 to 112, the output is the input magnitude rounded to the nearest integer multiple of 2^-24 with ties to even, encoded as a half subnormal.
- R6: A round-up carry out of the mantissa increments the exponent field. 0x387FE000 gives 0x0400, and 65520.0 (0x477FF000) gives 0x7C00.
- R7: Input exponent fields 0 to 101, which includes all single subnormals, produce a signed zero.
- R8: out_valid equals in_valid delayed by one clock, and a converted word appears on out_data one clock after it is presented. An active-low reset clears out_valid and out_data to 0.
- R9: While in_valid is low, the input word is ignored and out_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Output word qualifier, one cycle after in_valid |
| out_data | output | 16 | Half-precision bit pattern |

## Verification
The only state is the output register, so any wrong value appears at the ports in the cycle right after the input word is accepted. Each case can be checked one cycle after it is driven. The riskiest logic is the rounding: the tie-to-even decision, the carry across the subnormal-to-normal and finite-to-infinity boundaries, and the switch between fixed and exponent-relative rounding points. A bad choice at any of these changes only the lowest bit or the exponent field of a single result. For that reason the stimulus includes exact ties and values one unit to either side of them, next to a large random set compared against an independent arithmetic model.

// File: rtl/sp_to_hp_narrow.sv
module sp_to_hp_narrow (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [15:0] out_data
);
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] fr;
  assign sgn = in_data[31];
  assign ex  = in_data[30:23];
  assign fr  = in_data[22:0];

  logic is_nan, too_big, is_low;
  assign is_nan  = (ex == 8'hFF) && (fr != 23'd0);
  assign too_big = (ex >= 8'd143);
  assign is_low  = (ex < 8'd113);

  logic [23:0] sig;
  logic [7:0]  sh_raw;
  logic [4:0]  sh;
  logic [34:0] ext;
  assign sig    = {ex != 8'd0, fr};
  assign sh_raw = 8'd126 - ex;
  assign sh     = (sh_raw > 8'd26) ? 5'd26 : sh_raw[4:0];
  assign ext    = 35'({sig, 25'd0} >> sh);

  logic [7:0]  ex_adj;
  logic [14:0] pre;
  logic        rb, st, up;
  logic [14:0] sum, mag;
  assign ex_adj = ex - 8'd112;
  assign pre = is_low ? {5'd0, ext[34:25]} : {ex_adj[4:0], fr[22:13]};
  assign rb  = is_low ? ext[24] : fr[12];
  assign st  = is_low ? (|ext[23:0]) : (|fr[11:0]);
  assign up  = rb & (st | pre[0]);
  assign sum = pre + {14'd0, up};
  assign mag = is_nan ? 15'h7E00 : (too_big ? 15'h7C00 : sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 16'h0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= {sgn, mag};
    end
  end
endmodule

// File: rtl/sp_to_hp_narrow_chk.sv
module sp_to_hp_narrow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [15:0] out_data
);
  p_nan_canon_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0) |=> (out_data[14:0] == 15'h7E00));

  p_sat_inf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] >= 8'd143 && !(in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0))
      |=> (out_data[14:0] == 15'h7C00));

  p_sign_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[15] == $past(in_data[31])));

  p_flush_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[30:23] <= 8'd101) |=> (out_data[14:0] == 15'd0));

  p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

bind sp_to_hp_narrow sp_to_hp_narrow_chk u_chk (.*);

// File: tb/tb_sp_to_hp_narrow.sv
module tb_sp_to_hp_narrow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic [15:0] out_data;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sp_to_hp_narrow dut (.*);

  localparam int NV = 26;
  localparam logic [47:0] VEC [NV] = '{
    {32'h3F800000, 16'h3C00},  // R4 one
    {32'h00000000, 16'h0000},  // R7 zero
    {32'h80000000, 16'h8000},  // R3 R7 negative zero
    {32'h477FE000, 16'h7BFF},  // R4 65504
    {32'h477FF000, 16'h7C00},  // R6 65520 tie to inf
    {32'h477FEFFF, 16'h7BFF},  // R4 just below 65520
    {32'h7F800000, 16'h7C00},  // R2 +inf
    {32'hFF800000, 16'hFC00},  // R2 R3 -inf
    {32'h7FC00000, 16'h7E00},  // R1 quiet NaN
    {32'hFF800001, 16'hFE00},  // R1 R3 signalling NaN negative
    {32'h33800000, 16'h0001},  // R5 smallest subnormal
    {32'h33000000, 16'h0000},  // R5 half step tie to even zero
    {32'h33000001, 16'h0001},  // R5 above half step
    {32'h33C00000, 16'h0002},  // R5 tie 1.5 steps to 2
    {32'h38800000, 16'h0400},  // R4 smallest normal
    {32'h387FE000, 16'h0400},  // R6 subnormal carries to normal
    {32'h3F801000, 16'h3C00},  // R4 tie stays even
    {32'h3F803000, 16'h3C02},  // R4 tie rounds up to even
    {32'h3F802001, 16'h3C01},  // R4 below tie
    {32'h00000001, 16'h0000},  // R7 single subnormal
    {32'h80400000, 16'h8000},  // R7 negative single subnormal
    {32'h47800000, 16'h7C00},  // R2 65536
    {32'hC0490FDB, 16'hC248},  // R4 R3 minus pi
    {32'h32FFFFFF, 16'h0000},  // R7 exponent 101
    {32'hB3400000, 16'h8001},  // R5 R3 0.75 step
    {32'h4F000000, 16'h7C00}   // R2 large
  };

  function automatic logic [15:0] model(input logic [31:0] x);
    int e, k;
    longint sig, q, rem, half, mag;
    bit up;
    e = int'(x[30:23]);
    if (e == 255) return {x[31], (x[22:0] != 23'd0) ? 15'h7E00 : 15'h7C00};
    sig = longint'(x[22:0]);
    if (e != 0) sig = sig + (64'sd1 <<< 23);
    k = (e >= 113) ? 13 : (126 - e);
    if (k > 40) k = 40;
    q = sig >>> k;
    rem = sig - (q <<< k);
    half = 64'sd1 <<< (k - 1);
    up = (rem > half) || (rem == half && q[0]);
    if (e >= 113) mag = (longint'(e - 113) <<< 10) + q + longint'(up);
    else mag = q + longint'(up);
    if (mag >= 64'sh7C00) mag = 64'sh7C00;
    return {x[31], mag[14:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp, input logic [31:0] inw);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, inw, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [15:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    check(tag, out_data, exp, w);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    #5;
    check("R8 reset out_data", out_data, 16'h0000, 32'd0);
    check("R8 reset out_valid", {15'd0, out_valid}, 16'd0, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i][47:16], VEC[i][15:0], "R1-table");

    apply(32'h3F800000, 16'h3C00, "R4");
    check("R8 valid high after accept", {15'd0, out_valid}, 16'd1, 32'h3F800000);
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'h7FC00000;
    @(negedge clk);
    check("R8 valid low after idle", {15'd0, out_valid}, 16'd0, in_data);
    check("R9 data held while idle", out_data, held, in_data);
    @(negedge clk);
    check("R9 data still held", out_data, held, in_data);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 3 == 0) w[30:23] = 8'(95 + ($urandom % 55));
      if (i % 7 == 0) w[12:0] = 13'h1000;
      apply(w, model(w), "R4 R5 random");
    end

    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h40000000;
    #3 rst_n = 1'b0;
    #2;
    check("R8 async reset valid", {15'd0, out_valid}, 16'd0, in_data);
    check("R8 async reset data", out_data, 16'h0000, in_data);
    @(negedge clk);
    rst_n = 1'b1;
    apply(32'h40000000, 16'h4000, "R4 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule